// File: doc/BRIEF.md
# Palette Entry Format Converter

The converter turns a raw palette, streamed in one source entry per beat, into internal palette RAM writes. Each RAM entry holds 8-bit red, green and blue components plus a transparency flag. A 2-bit format selector chooses how wide the source entry is and where its colour fields sit. A monochrome control bit replaces the colour decode with a single grey level. The current pixel depth code sets how many entries one parse produces.

A parse starts with a one-cycle `start_i` pulse, which stands for the arrival of a palette-load frame. At that pulse the block captures the format, the monochrome bit and the depth. It then accepts source beats until the entry count is reached, writing one RAM entry per beat at indices 0, 1, 2 and so on, and pulses `done_o` after the last write. The input stream uses valid/ready. `in_ready_o` is high for the whole parse and low at all other times. The source may stall by dropping `in_valid_i` between beats. The RAM side has no back-pressure: a write is always taken. Apart from parsing, the block tracks which format the palette was last parsed with. `stale_o` tells the surrounding controller that the palette must be parsed again.

Top module: `pal_convert`

## Requirements
- R1: Depth code 1 parses 4 entries, code 2 parses 16 and code 3 parses 256. A start pulse with any other depth code is ignored: `in_ready_o` stays low, no write and no `done_o` occur, and `stale_o` is unchanged.
- R2: Format 0 takes a 16-bit entry from data bits 15:0. Red comes from bits 15:11, green from bits 10:5 and blue from bits 4:0, and alpha is 0.
- R3: Format 1 takes a 32-bit entry. Red comes from bits 23:19, green from bits 15:10, blue from bits 7:3, and alpha from bit 24.
- R4: Format 2 takes a 32-bit entry. Red comes from bits 23:18, green from bits 15:10, blue from bits 7:2, and alpha from bit 24.
- R5: Format 3 takes a 32-bit entry. Red comes from bits 23:16, green from bits 15:8, blue from bits 7:0, and alpha from bit 24.
- R6: With monochrome set, red, green and blue all equal data bits 7:0 in every format. Alpha still follows the format (0 in format 0, bit 24 otherwise).
- R7: Each component is left-aligned into 8 bits with zero fill below it. `wr_data_o` packs alpha at bit 24, red at 23:16, green at 15:8 and blue at 7:0.
- R8: Each accepted beat (`in_valid_i` and `in_ready_o` both high at a clock edge) produces exactly one `wr_en_o` pulse one cycle later. The writes go to consecutive indices starting at 0, and the source may insert idle cycles between beats.
- R9: `done_o` pulses for one cycle, one cycle after the write of the last entry, and `in_ready_o` is low from that last write onward.
- R10: Format, monochrome and depth are captured at the accepted start. Changes to those inputs during a parse do not affect the entries produced.
- R11: A start pulse during a parse is ignored. Indexing, count and decode continue unchanged.
- R12: `stale_o` is high after reset. It is low right after an accepted start while `pal_fmt_i` keeps the value used for that parse. It is high whenever `pal_fmt_i` differs from that value.
- R13: After reset `in_ready_o`, `wr_en_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Palette-load frame arrived; begin a parse |
| pal_fmt_i | input | 2 | Palette source format selector |
| mono_i | input | 1 | Monochrome override |
| depth_i | input | 4 | Pixel depth code (1, 2, 3 are palettised) |
| in_valid_i | input | 1 | Source entry valid |
| in_ready_o | output | 1 | Converter accepts a source entry |
| in_data_i | input | 32 | Raw source entry |
| wr_en_o | output | 1 | Palette RAM write strobe |
| wr_idx_o | output | 8 | Palette RAM write index |
| wr_data_o | output | 25 | Converted entry {alpha, red, green, blue} |
| done_o | output | 1 | Parse complete pulse |
| stale_o | output | 1 | Palette must be parsed again |

## Verification
A corrupted entry counter shows at the ports as a write index that skips or repeats within a cycle of the fault. It also moves `done_o` to the wrong beat, so a full 256-entry parse exposes any counter-width fault by the end of the parse. A wrong captured format or monochrome bit corrupts the very next write word, and each format is driven with patterns whose fields differ, so a swapped slice appears at once. The format tracker is seen through `stale_o` one cycle after a start and combinationally whenever the format input moves.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int COMP_W = 8;

  typedef struct packed {
    logic              alpha;
    logic [COMP_W-1:0] red;
    logic [COMP_W-1:0] green;
    logic [COMP_W-1:0] blue;
  } pal_entry_t;

  typedef enum logic [1:0] {
    PF_RGB565  = 2'd0,
    PF_RGB555A = 2'd1,
    PF_RGB666A = 2'd2,
    PF_RGB888A = 2'd3
  } pal_fmt_e;

endpackage

// File: rtl/pal_decode.sv
module pal_decode
  import pal_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  pal_fmt_e          fmt_i,
  input  logic              mono_i,
  input  logic [DATA_W-1:0] data_i,
  output pal_entry_t        entry_o
);

  localparam int ALPHA_BIT = 24;

  pal_entry_t colour;

  always_comb begin
    colour = '0;
    unique case (fmt_i)
      PF_RGB565: begin
        colour.red   = {data_i[15:11], 3'b000};
        colour.green = {data_i[10:5],  2'b00};
        colour.blue  = {data_i[4:0],   3'b000};
        colour.alpha = 1'b0;
      end
      PF_RGB555A: begin
        colour.red   = {data_i[23:19], 3'b000};
        colour.green = {data_i[15:10], 2'b00};
        colour.blue  = {data_i[7:3],   3'b000};
        colour.alpha = data_i[ALPHA_BIT];
      end
      PF_RGB666A: begin
        colour.red   = {data_i[23:18], 2'b00};
        colour.green = {data_i[15:10], 2'b00};
        colour.blue  = {data_i[7:2],   2'b00};
        colour.alpha = data_i[ALPHA_BIT];
      end
      default: begin
        colour.red   = data_i[23:16];
        colour.green = data_i[15:8];
        colour.blue  = data_i[7:0];
        colour.alpha = data_i[ALPHA_BIT];
      end
    endcase
  end

  always_comb begin
    entry_o = colour;
    if (mono_i) begin
      entry_o.red   = data_i[COMP_W-1:0];
      entry_o.green = data_i[COMP_W-1:0];
      entry_o.blue  = data_i[COMP_W-1:0];
    end
  end

endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int DEPTH_W  = 4,
  parameter int MAX_CODE = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [DEPTH_W-1:0]      depth_i,
  input  pal_fmt_e                fmt_i,
  input  logic                    mono_i,
  output pal_fmt_e                fmt_q_o,
  output logic                    mono_q_o,
  output logic                    accept_o,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  pal_entry_t              entry_i,
  output logic                    wr_en_o,
  output logic [(1<<MAX_CODE)-1:0] wr_idx_o,
  output pal_entry_t              wr_data_o,
  output logic                    done_o
);

  localparam int IDX_W = 1 << MAX_CODE;
  localparam int CNT_W = IDX_W + 1;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             depth_ok;
  logic             beat;
  logic             wr_last;
  logic [CNT_W-1:0] n_entries;

  always_comb begin
    depth_ok  = (depth_i >= DEPTH_W'(1)) && (depth_i <= DEPTH_W'(MAX_CODE));
    n_entries = '0;
    if (depth_ok) n_entries = CNT_W'(1) << (1 << depth_i);
  end

  assign accept_o   = start_i && !busy && depth_ok;
  assign in_ready_o = busy;
  assign beat       = in_valid_i && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      last_cnt <= '0;
      fmt_q_o  <= PF_RGB565;
      mono_q_o <= 1'b0;
    end else if (accept_o) begin
      busy     <= 1'b1;
      cnt      <= '0;
      last_cnt <= n_entries - CNT_W'(1);
      fmt_q_o  <= fmt_i;
      mono_q_o <= mono_i;
    end else if (beat) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt == last_cnt) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      wr_last   <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      wr_en_o <= beat;
      wr_last <= beat && (cnt == last_cnt);
      done_o  <= wr_last;
      if (beat) begin
        wr_idx_o  <= cnt[IDX_W-1:0];
        wr_data_o <= entry_i;
      end
    end
  end

  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(busy)); // R8

  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_en_o)); // R9

endmodule

// File: rtl/pal_track.sv
module pal_track
  import pal_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept_i,
  input  pal_fmt_e fmt_i,
  output logic     stale_o
);

  logic     have_q;
  pal_fmt_e used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      used_q <= PF_RGB565;
    end else if (accept_i) begin
      have_q <= 1'b1;
      used_q <= fmt_i;
    end
  end

  assign stale_o = !have_q || (fmt_i != used_q);

  AST_FRESH_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (!stale_o || !$stable(fmt_i))); // R12

endmodule

// File: rtl/pal_convert.sv
module pal_convert
  import pal_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH_W  = 4,
  parameter int MAX_CODE = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [1:0]               pal_fmt_i,
  input  logic                     mono_i,
  input  logic [DEPTH_W-1:0]       depth_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [DATA_W-1:0]        in_data_i,
  output logic                     wr_en_o,
  output logic [(1<<MAX_CODE)-1:0] wr_idx_o,
  output logic [24:0]              wr_data_o,
  output logic                     done_o,
  output logic                     stale_o
);

  pal_fmt_e   fmt_in;
  pal_fmt_e   fmt_q;
  logic       mono_q;
  logic       accept;
  pal_entry_t entry;
  pal_entry_t wr_entry;

  assign fmt_in = pal_fmt_e'(pal_fmt_i);

  pal_decode #(.DATA_W(DATA_W)) u_decode (
    .fmt_i   (fmt_q),
    .mono_i  (mono_q),
    .data_i  (in_data_i),
    .entry_o (entry)
  );

  pal_seq #(.DEPTH_W(DEPTH_W), .MAX_CODE(MAX_CODE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .depth_i    (depth_i),
    .fmt_i      (fmt_in),
    .mono_i     (mono_i),
    .fmt_q_o    (fmt_q),
    .mono_q_o   (mono_q),
    .accept_o   (accept),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .entry_i    (entry),
    .wr_en_o    (wr_en_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_entry),
    .done_o     (done_o)
  );

  pal_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .fmt_i    (fmt_in),
    .stale_o  (stale_o)
  );

  assign wr_data_o = wr_entry;

  AST_MONO_GREY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(mono_q)) |->
      (wr_entry.red == wr_entry.green && wr_entry.green == wr_entry.blue)); // R6

  AST_FMT0_NO_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(fmt_q == PF_RGB565)) |-> !wr_entry.alpha); // R2

endmodule

// File: tb/test_pal_convert.sv
`timescale 1ns/1ps
module test_pal_convert;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  pal_fmt_i = 2'd0;
  logic        mono_i = 1'b0;
  logic [3:0]  depth_i = 4'd0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] in_data_i = '0;
  logic        wr_en_o;
  logic [7:0]  wr_idx_o;
  logic [24:0] wr_data_o;
  logic        done_o;
  logic        stale_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  pal_convert i_pal_convert (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pal_fmt_i(pal_fmt_i),
    .mono_i(mono_i), .depth_i(depth_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_data_i(in_data_i), .wr_en_o(wr_en_o),
    .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .done_o(done_o),
    .stale_o(stale_o)
  );

  function automatic logic [24:0] expect_entry(input logic [1:0] f,
                                               input logic m,
                                               input logic [31:0] d);
    logic [7:0] r, g, b;
    logic a;
    case (f)
      2'd0: begin r = {d[15:11],3'b0}; g = {d[10:5],2'b0}; b = {d[4:0],3'b0}; a = 1'b0; end
      2'd1: begin r = {d[23:19],3'b0}; g = {d[15:10],2'b0}; b = {d[7:3],3'b0}; a = d[24]; end
      2'd2: begin r = {d[23:18],2'b0}; g = {d[15:10],2'b0}; b = {d[7:2],2'b0}; a = d[24]; end
      default: begin r = d[23:16]; g = d[15:8]; b = d[7:0]; a = d[24]; end
    endcase
    if (m) begin r = d[7:0]; g = d[7:0]; b = d[7:0]; end
    return {a, r, g, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] f, input logic m, input logic [3:0] dep);
    @(negedge clk);
    start_i = 1'b1; pal_fmt_i = f; mono_i = m; depth_i = dep;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one beat; checks write strobe, index and data one cycle after the handshake
  task automatic beat(input string req, input logic [31:0] d, input int idx,
                      input logic [24:0] exp);
    in_valid_i = 1'b1; in_data_i = d;
    @(negedge clk);
    in_valid_i = 1'b0;
    check({req, " wr_en"}, 32'(wr_en_o), 32'd1);
    check("R8 index", 32'(wr_idx_o), 32'(idx));
    check({req, " data"}, 32'(wr_data_o), 32'(exp));
  endtask

  task automatic t_reset;
    check("R13 ready", 32'(in_ready_o), 0);
    check("R13 wr_en", 32'(wr_en_o), 0);
    check("R13 done", 32'(done_o), 0);
    check("R12 stale after reset", 32'(stale_o), 1);
  endtask

  task automatic t_format(input logic [1:0] f, input logic m, input string req);
    logic [31:0] d;
    do_start(f, m, 4'd1);
    check("R12 fresh", 32'(stale_o), 0);
    check("R8 ready in parse", 32'(in_ready_o), 1);
    for (int i = 0; i < 4; i++) begin
      d = 32'h01A5_C3E7 ^ (32'h0135_7F9B * i) ^ (i[0] ? 32'h0100_0000 : 32'h0);
      beat(req, d, i, expect_entry(f, m, d));
      if (i == 1) begin
        // source stall
        @(negedge clk);
        check("R8 no write on idle", 32'(wr_en_o), 0);
      end
    end
    check("R9 ready low after last", 32'(in_ready_o), 0);
    check("R9 done", 32'(done_o), 0);
    @(negedge clk);
    check("R9 done", 32'(done_o), 1);
    @(negedge clk);
    check("R9 done one cycle", 32'(done_o), 0);
  endtask

  task automatic t_count(input logic [3:0] dep, input int n);
    do_start(2'd3, 1'b0, dep);
    for (int i = 0; i < n; i++) begin
      beat("R1", 32'(i * 32'h0001_0203), i, expect_entry(2'd3, 1'b0, 32'(i * 32'h0001_0203)));
      if (i == n - 1) check("R1 ready drops at count", 32'(in_ready_o), 0);
    end
    @(negedge clk);
    check("R1 done at count", 32'(done_o), 1);
  endtask

  task automatic t_bad_depth;
    logic s;
    pal_fmt_i = 2'd2;
    @(negedge clk);
    s = stale_o;
    do_start(2'd2, 1'b0, 4'd4);
    check("R1 bad depth ready", 32'(in_ready_o), 0);
    in_valid_i = 1'b1; in_data_i = 32'h1234_5678;
    @(negedge clk);
    in_valid_i = 1'b0;
    @(negedge clk);
    check("R1 bad depth no write", 32'(wr_en_o), 0);
    check("R1 bad depth no done", 32'(done_o), 0);
    check("R1 bad depth stale", 32'(stale_o), 32'(s));
  endtask

  task automatic t_mid_change;
    logic [31:0] d;
    do_start(2'd1, 1'b0, 4'd1);
    for (int i = 0; i < 4; i++) begin
      d = 32'h01F8_FCF8 - 32'(i * 32'h0008_0408);
      if (i == 1) begin
        // start ignored while busy, inputs changed
        start_i = 1'b1; pal_fmt_i = 2'd3; mono_i = 1'b1; depth_i = 4'd3;
        @(negedge clk);
        start_i = 1'b0;
        check("R11 still ready", 32'(in_ready_o), 1);
      end
      beat("R10", d, i, expect_entry(2'd1, 1'b0, d));
    end
    check("R11 stale on changed fmt", 32'(stale_o), 1);
    @(negedge clk);
    check("R11 done at original count", 32'(done_o), 1);
    pal_fmt_i = 2'd1;
    #0.5;
    check("R12 fresh with used fmt", 32'(stale_o), 0);
  endtask

  initial begin
    #150_000;
    n_fail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_format(2'd0, 1'b0, "R2");
    t_format(2'd1, 1'b0, "R3");
    t_format(2'd2, 1'b0, "R4");
    t_format(2'd3, 1'b0, "R5");
    t_format(2'd0, 1'b1, "R6");
    t_format(2'd2, 1'b1, "R6");
    t_format(2'd1, 1'b0, "R7");
    pal_fmt_i = 2'd0;
    #0.5;
    check("R12 stale on format change", 32'(stale_o), 1);
    t_count(4'd2, 16);
    t_count(4'd3, 256);
    t_bad_depth();
    t_mid_change();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule